// File: doc/BRIEF.md
# Stream-to-Write-Master Bridge

This block connects a valid/ready streaming source to a memory-mapped master port that only writes. Every stream beat the block accepts becomes one write. The write strobe follows the stream valid, and the stream is stalled for as long as the slave holds its wait request. The stream's sideband signals are packed next to the payload, so the write word is wider than the stream data. These are start-of-packet, end-of-packet, the empty count, the channel number and the error flag.

The channel number selects the destination. It is scaled by a fixed byte stride to form the write address. The address therefore comes from the stream side, which is why this side of the bridge is a master and not a slave. A parameter chooses between two variants. One is a purely combinational path. The other adds one registered stage with a one-entry side store, which breaks the timing path while keeping one beat per cycle.

Top module: `st2mm_wbridge`

## Requirements
- R1: In the combinational variant (REG_STAGE=0), when reset is low, `m_write` equals `s_valid` in the same cycle.
- R2: In the combinational variant, `s_ready` is the inverse of `m_waitreq`. A beat is consumed only in a cycle where `m_write` is high and `m_waitreq` is low.
- R3: `m_addr` equals the beat's channel number multiplied by STRIDE bytes. With the defaults this is channel times 8.
- R4: With the defaults, `m_wdata` is 41 bits and holds the fields below. No field is taken from a different beat.

  | Bits | Field |
  |------|-------|
  | [31:0] | data |
  | [32] | start-of-packet |
  | [33] | end-of-packet |
  | [35:34] | empty |
  | [39:36] | channel |
  | [40] | error |

- R5: Reset is synchronous and active high. While reset is high, `m_write` and `s_ready` are low. Beats held in the registered variant are discarded by reset and never written.
- R6: In the registered variant (REG_STAGE=1), while `m_write` is high and `m_waitreq` is high, `m_write`, `m_addr` and `m_wdata` hold their values into the next cycle.
- R7: In the registered variant, a beat accepted into an empty stage appears on the write port one cycle later. With `m_waitreq` low, one beat is written every cycle.
- R8: In the registered variant, a beat accepted while the output is stalled is held in a one-entry side store. `s_ready` drops only while that store is occupied. No beat is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat ready |
| s_data | input | DATA_W | Stream payload |
| s_sop | input | 1 | Start-of-packet flag |
| s_eop | input | 1 | End-of-packet flag |
| s_err | input | 1 | Error flag |
| s_empty | input | EMPTY_W | Count of unused symbols in the beat |
| s_chan | input | CHAN_W | Channel number |
| m_write | output | 1 | Write strobe |
| m_waitreq | input | 1 | Slave stall request |
| m_addr | output | ADDR_W | Byte address of the write |
| m_wdata | output | DATA_W+EMPTY_W+CHAN_W+3 | Packed write word |

## Verification
In the registered variant, two things can happen in the same cycle. The slave can release its wait request on the held output beat while the source presents a new beat. The side store then has to be drained into the output register at the same edge, or the new beat has to be taken in directly. The bench provokes this by pairing a wait-request pattern with a stream-valid pattern of a different period, including a long stall. It judges the result with an in-order scoreboard that compares every written word and address with the beat expected at that position. It also compares the final written count with the accepted count, and checks that the outputs held steady in every stalled cycle.

// File: rtl/st2mm_pkg.sv
package st2mm_pkg;

  typedef enum logic [2:0] {
    FLD_DATA,
    FLD_SOP,
    FLD_EOP,
    FLD_EMPTY,
    FLD_CHAN,
    FLD_ERR
  } fld_e;

  // Low bit of each field inside the packed write word.
  function automatic int fld_lsb(input fld_e f, input int data_w,
                                 input int empty_w, input int chan_w);
    case (f)
      FLD_DATA:  return 0;
      FLD_SOP:   return data_w;
      FLD_EOP:   return data_w + 1;
      FLD_EMPTY: return data_w + 2;
      FLD_CHAN:  return data_w + 2 + empty_w;
      default:   return data_w + 2 + empty_w + chan_w;
    endcase
  endfunction

  function automatic int word_width(input int data_w, input int empty_w,
                                    input int chan_w);
    return fld_lsb(FLD_ERR, data_w, empty_w, chan_w) + 1;
  endfunction

endpackage

// File: rtl/st2mm_pack.sv
module st2mm_pack
  import st2mm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EMPTY_W = 2,
  parameter int CHAN_W  = 4,
  parameter int ADDR_W  = 16,
  parameter int STRIDE  = 8,
  localparam int WORD_W = word_width(DATA_W, EMPTY_W, CHAN_W)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic               sop,
  input  logic               eop,
  input  logic               err,
  input  logic [EMPTY_W-1:0] empty,
  input  logic [CHAN_W-1:0]  chan,
  output logic [WORD_W-1:0]  word,
  output logic [ADDR_W-1:0]  addr
);

  localparam int L_SOP   = fld_lsb(FLD_SOP,   DATA_W, EMPTY_W, CHAN_W);
  localparam int L_EOP   = fld_lsb(FLD_EOP,   DATA_W, EMPTY_W, CHAN_W);
  localparam int L_EMPTY = fld_lsb(FLD_EMPTY, DATA_W, EMPTY_W, CHAN_W);
  localparam int L_CHAN  = fld_lsb(FLD_CHAN,  DATA_W, EMPTY_W, CHAN_W);
  localparam int L_ERR   = fld_lsb(FLD_ERR,   DATA_W, EMPTY_W, CHAN_W);

  function automatic logic [ADDR_W-1:0] chan_to_addr(input logic [CHAN_W-1:0] c);
    return ADDR_W'(c) * ADDR_W'(STRIDE);
  endfunction

  always_comb begin
    word                           = '0;
    word[DATA_W-1:0]               = data;
    word[L_SOP]                    = sop;
    word[L_EOP]                    = eop;
    word[L_EMPTY +: EMPTY_W]       = empty;
    word[L_CHAN +: CHAN_W]         = chan;
    word[L_ERR]                    = err;
  end

  assign addr = chan_to_addr(chan);

endmodule

// File: rtl/st2mm_stage.sv
module st2mm_stage #(
  parameter int PL_W      = 57,
  parameter bit REG_STAGE = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PL_W-1:0] in_pl,
  output logic            out_valid,
  input  logic            out_stall,
  output logic [PL_W-1:0] out_pl
);

  if (REG_STAGE) begin : g_reg
    logic            ov_q;
    logic            sf_q;
    logic [PL_W-1:0] opl_q;
    logic [PL_W-1:0] spl_q;
    logic            beat_in;
    logic            beat_out;
    logic            out_free;

    assign in_ready  = ~sf_q & ~rst;
    assign beat_in   = in_valid & in_ready;
    assign beat_out  = ov_q & ~out_stall;
    assign out_free  = beat_out | ~ov_q;
    assign out_valid = ov_q;
    assign out_pl    = opl_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        ov_q <= 1'b0;
        sf_q <= 1'b0;
      end else if (out_free) begin
        ov_q <= sf_q | beat_in;
        sf_q <= 1'b0;
        if (sf_q)         opl_q <= spl_q;
        else if (beat_in) opl_q <= in_pl;
      end else if (beat_in) begin
        spl_q <= in_pl;
        sf_q  <= 1'b1;
      end
    end

    // R6
    hold_under_wait_chk: assert property (@(posedge clk) disable iff (rst)
      (ov_q && out_stall) |=> (out_valid && $stable(out_pl)));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (sf_q && ov_q && out_stall) |=> (sf_q && $stable(spl_q) && !in_ready));

    // R7
    one_cycle_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (beat_in && !sf_q && out_free) |=> (out_valid && out_pl == $past(in_pl)));
  end else begin : g_comb
    logic beat_in;

    assign out_valid = in_valid & ~rst;
    assign in_ready  = ~out_stall & ~rst;
    assign out_pl    = in_pl;
    assign beat_in   = in_valid & in_ready;

    // R2
    consume_on_write_chk: assert property (@(posedge clk) disable iff (rst)
      beat_in |-> (out_valid && !out_stall));
  end

endmodule

// File: rtl/st2mm_wbridge.sv
module st2mm_wbridge
  import st2mm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int EMPTY_W   = 2,
  parameter int CHAN_W    = 4,
  parameter int ADDR_W    = 16,
  parameter int STRIDE    = 8,
  parameter bit REG_STAGE = 1'b0,
  localparam int WORD_W   = word_width(DATA_W, EMPTY_W, CHAN_W),
  localparam int PL_W     = WORD_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [DATA_W-1:0]  s_data,
  input  logic               s_sop,
  input  logic               s_eop,
  input  logic               s_err,
  input  logic [EMPTY_W-1:0] s_empty,
  input  logic [CHAN_W-1:0]  s_chan,
  output logic               m_write,
  input  logic               m_waitreq,
  output logic [ADDR_W-1:0]  m_addr,
  output logic [WORD_W-1:0]  m_wdata
);

  logic [WORD_W-1:0] packed_word;
  logic [ADDR_W-1:0] packed_addr;
  logic [PL_W-1:0]   stage_out;
  logic              beat_taken;
  logic              write_done;

  st2mm_pack #(
    .DATA_W (DATA_W),
    .EMPTY_W(EMPTY_W),
    .CHAN_W (CHAN_W),
    .ADDR_W (ADDR_W),
    .STRIDE (STRIDE)
  ) u_pack (
    .data (s_data),
    .sop  (s_sop),
    .eop  (s_eop),
    .err  (s_err),
    .empty(s_empty),
    .chan (s_chan),
    .word (packed_word),
    .addr (packed_addr)
  );

  st2mm_stage #(
    .PL_W     (PL_W),
    .REG_STAGE(REG_STAGE)
  ) u_stage (
    .clk      (clk),
    .rst      (rst),
    .in_valid (s_valid),
    .in_ready (s_ready),
    .in_pl    ({packed_addr, packed_word}),
    .out_valid(m_write),
    .out_stall(m_waitreq),
    .out_pl   (stage_out)
  );

  assign m_addr     = stage_out[PL_W-1 -: ADDR_W];
  assign m_wdata    = stage_out[WORD_W-1:0];
  assign beat_taken = s_valid & s_ready;
  assign write_done = m_write & ~m_waitreq;

  // R3
  addr_stride_chk: assert property (@(posedge clk) disable iff (rst)
    m_write |-> ((32'(m_addr) % STRIDE) == 0));

  // R2
  take_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!REG_STAGE && beat_taken) |-> write_done);

endmodule

// File: tb/st2mm_wbridge_bench.sv
module st2mm_wbridge_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // combinational instance stimulus
  logic        s_valid = 0, s_sop = 0, s_eop = 0, s_err = 0, m_waitreq = 0;
  logic [31:0] s_data = 0;
  logic [1:0]  s_empty = 0;
  logic [3:0]  s_chan = 0;
  logic        s_ready, m_write;
  logic [15:0] m_addr;
  logic [40:0] m_wdata;

  // registered instance stimulus
  logic        r_valid = 0, r_sop = 0, r_eop = 0, r_err = 0, r_waitreq = 0;
  logic [31:0] r_data = 0;
  logic [1:0]  r_empty = 0;
  logic [3:0]  r_chan = 0;
  logic        r_ready, r_write;
  logic [15:0] r_addr;
  logic [40:0] r_wdata;

  st2mm_wbridge u_st2mm_wbridge (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sop(s_sop), .s_eop(s_eop), .s_err(s_err),
    .s_empty(s_empty), .s_chan(s_chan), .m_write(m_write),
    .m_waitreq(m_waitreq), .m_addr(m_addr), .m_wdata(m_wdata));

  st2mm_wbridge #(.REG_STAGE(1'b1)) u_st2mm_wbridge_reg (
    .clk(clk), .rst(rst), .s_valid(r_valid), .s_ready(r_ready),
    .s_data(r_data), .s_sop(r_sop), .s_eop(r_eop), .s_err(r_err),
    .s_empty(r_empty), .s_chan(r_chan), .m_write(r_write),
    .m_waitreq(r_waitreq), .m_addr(r_addr), .m_wdata(r_wdata));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Word layout restated arithmetically (R4).
  function automatic logic [40:0] exp_word(input logic err, input logic [3:0] chan,
      input logic [1:0] empty, input logic eop, input logic sop, input logic [31:0] data);
    logic [40:0] w;
    w = 41'(data);
    w = w + (41'(sop) << 32) + (41'(eop) << 33) + (41'(empty) << 34);
    w = w + (41'(chan) << 36) + (41'(err) << 40);
    return w;
  endfunction

  // Beat number i of the registered-mode stream.
  function automatic logic [44:0] beat_fields(input int i);
    logic [31:0] d;
    d = 32'(i) * 32'h0100_0193 + 32'h55;
    return {(i % 9) == 8, 4'(i), (i % 4) == 3 ? 2'(i % 3) : 2'd0,
            (i % 4) == 3, (i % 4) == 0, d, 4'd0};
  endfunction

  // valid, waitreq, err, chan, empty, eop, sop, data, exp_write, exp_ready
  localparam logic [44:0] TBL [8] = '{
    {1'b1, 1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 1'b1, 32'h1234_5678, 1'b1, 1'b1},
    {1'b1, 1'b1, 1'b1, 4'hF, 2'd3, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b0, 4'h5, 2'd1, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b1, 4'hA, 2'd2, 1'b0, 1'b0, 32'hDEAD_BEEF, 1'b0, 1'b0},
    {1'b1, 1'b0, 1'b1, 4'h7, 2'd2, 1'b0, 1'b0, 32'h0F0F_0F0F, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b0, 4'h8, 2'd0, 1'b1, 1'b1, 32'h8000_0001, 1'b1, 1'b1},
    {1'b1, 1'b1, 1'b0, 4'h3, 2'd1, 1'b1, 1'b0, 32'hCAFE_0000, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b1, 4'hC, 2'd3, 1'b0, 1'b1, 32'h0000_FFFF, 1'b0, 1'b1}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  int in_idx = 0, out_idx = 0, out_cnt = 0, ready_low = 0;
  logic        prev_stall = 0;
  logic [40:0] prev_word  = 0;
  logic [15:0] prev_addr  = 0;

  // One registered-mode cycle: drive at negedge, judge just before posedge.
  task automatic reg_cycle(input logic v, input logic w);
    logic [44:0] bf;
    logic [44:0] of;
    @(negedge clk);
    bf = beat_fields(in_idx);
    r_valid = v; r_waitreq = w;
    {r_err, r_chan, r_empty, r_eop, r_sop, r_data} = bf[44:4];
    #3;
    if (r_write && prev_stall) begin
      // R6
      check(r_wdata == prev_word && r_addr == prev_addr, "R6 hold", r_wdata, prev_word);
    end
    if (r_write && !r_waitreq) begin
      of = beat_fields(out_idx);
      // R8 order, R4 packing
      check(r_wdata == exp_word(of[44], of[43:40], of[39:38], of[37], of[36], of[35:4]),
            "R8 order/R4 word", r_wdata,
            exp_word(of[44], of[43:40], of[39:38], of[37], of[36], of[35:4]));
      // R3
      check(r_addr == 16'(of[43:40]) * 16'd8, "R3 addr", r_addr, 16'(of[43:40]) * 16'd8);
      out_idx++;
      out_cnt++;
    end
    if (r_valid && !r_ready) ready_low++;
    if (r_valid && r_ready) in_idx++;
    prev_stall = r_write & r_waitreq;
    prev_word  = r_wdata;
    prev_addr  = r_addr;
  endtask

  initial begin
    // R5: reset holds both variants quiet even with valid offered
    s_valid = 1; r_valid = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(m_write == 0 && s_ready == 0, "R5 comb reset", {m_write, s_ready}, 0);
    check(r_write == 0 && r_ready == 0, "R5 reg reset", {r_write, r_ready}, 0);
    s_valid = 0; r_valid = 0;
    rst = 0;

    // R1/R2/R3/R4: table walk on the combinational variant
    for (int k = 0; k < 8; k++) begin
      logic [44:0] e;
      logic [40:0] xw;
      @(negedge clk);
      e = TBL[k];
      {s_valid, m_waitreq, s_err, s_chan, s_empty, s_eop, s_sop, s_data} = e[44:2];
      #2;
      xw = exp_word(e[42], e[41:38], e[37:36], e[35], e[34], e[33:2]);
      check(m_write == e[1], "R1 write", m_write, e[1]);
      check(s_ready == e[0], "R2 ready", s_ready, e[0]);
      check(m_addr == 16'(e[41:38]) * 16'd8, "R3 addr", m_addr, 16'(e[41:38]) * 16'd8);
      check(m_wdata == xw, "R4 word", m_wdata, xw);
    end
    @(negedge clk);
    s_valid = 0; m_waitreq = 0;

    // R7: full throughput, one cycle latency
    for (int c = 0; c < 24; c++) reg_cycle(1'b1, 1'b0);
    check(out_cnt == 23, "R7 throughput", out_cnt, 23);
    check(in_idx == 24, "R7 ready held", in_idx, 24);

    // R8/R6: mixed stall and gap patterns, with a long stall
    for (int c = 0; c < 80; c++)
      reg_cycle((c % 7) != 6, ((c % 5) >= 3) || (c >= 40 && c < 48));
    for (int c = 0; c < 5; c++) reg_cycle(1'b0, 1'b0);
    check(out_idx == in_idx, "R8 no loss", out_idx, in_idx);
    check(ready_low > 0, "R8 ready drop", ready_low, 1);

    // R5: reset flushes held beats
    for (int c = 0; c < 3; c++) reg_cycle(1'b1, 1'b1);
    @(negedge clk);
    rst = 1;
    #2;
    check(r_ready == 0, "R5 ready in reset", r_ready, 0);
    @(negedge clk);
    check(r_write == 0, "R5 write after reset", r_write, 0);
    rst = 0; r_valid = 0; r_waitreq = 0;
    @(negedge clk);
    check(r_write == 0, "R5 flushed", r_write, 0);
    summary();
  end

endmodule